// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block derives two audio clocks from one of two source clocks. Everything runs in one system clock domain. Each source clock reaches the block as a stream of edge strobes. A strobe is a one-cycle pulse, and there is one for every rising edge and one for every falling edge of that source. So a source strobe stream carries two strobes per source period.

A select bit picks the stream to use. Two independent 6-bit dividers then turn the chosen stream into a master clock and a bit clock. Each divider toggles its output after a programmable number of source edges. A divider value of zero passes the source through unchanged.

The master clock can be switched off with a mode bit. The bit clock can come from the internal divider or from an external pin in the system domain. The serializer gets a one-cycle tick on every rising edge of the bit clock. Separate start and stop strobes control whether the dividers run. When the dividers are stopped, every output is held low and every counter is cleared.

Top module: `audclk_gen`

## Requirements
- R1: After reset, `mclk`, `bclk` and `bclk_tick` are 0 and the block is stopped.
- R2: `src_sel` = 0 selects the `edge_periph` strobe stream and `src_sel` = 1 selects `edge_gen`. Strobes on the stream that is not selected have no effect on any output.
- R3: With `bclk_int_sel` = 1 and an active bit divider value N > 0, `bclk` toggles on every 2N-th selected edge strobe. This gives 2N strobes high and then 2N strobes low (divide by 2N, 50 % duty). The first toggle after a start comes after a full 2N strobes.
- R4: An active divider value of 0 bypasses the divider. The output toggles on every selected edge strobe, so it equals the selected source clock.
- R5: With `mclk_gen_en` = 1, `mclk` follows the same arithmetic as R3 and R4, using `mclk_div` in place of `bclk_div`.
- R6: While `mclk_gen_en` = 0, the master divider is held cleared, and `mclk` is 0 from the next cycle on.
- R7: `bclk_tick` is a one-cycle pulse. It is high exactly in the cycle in which `bclk` has just gone from 0 to 1, and at no other time.
- R8: `clk_on` starts the dividers and `clk_off` stops them. If both arrive in the same cycle, `clk_off` wins. A strobe arriving in the same cycle as `clk_on` is not counted. While the block is stopped, the outputs stay 0 and the counters restart from zero.
- R9: A new divider value takes effect only when the current half period wraps. The half period in progress completes with the old value. While the block is stopped, the value is taken at once.
- R10: With `bclk_int_sel` = 0 and the block running, `bclk` equals `ext_bclk` delayed by one cycle. `bclk_tick` pulses one cycle after each 0-to-1 change of `ext_bclk`. When the block is stopped, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_periph | input | 1 | Edge strobe stream of the peripheral source clock |
| edge_gen | input | 1 | Edge strobe stream of the generated source clock |
| src_sel | input | 1 | Source select: 0 = peripheral, 1 = generated |
| mclk_div | input | DIV_W | Master divider value (0 = bypass) |
| bclk_div | input | DIV_W | Bit clock divider value (0 = bypass) |
| mclk_gen_en | input | 1 | 1 = produce the master clock |
| bclk_int_sel | input | 1 | 1 = internal bit clock, 0 = external bit clock |
| ext_bclk | input | 1 | External bit clock, already in the system domain |
| clk_on | input | 1 | Start strobe |
| clk_off | input | 1 | Stop strobe, has priority over `clk_on` |
| mclk | output | 1 | Master clock level |
| bclk | output | 1 | Bit clock level |
| bclk_tick | output | 1 | One-cycle pulse on each bit clock rising edge |

## Verification
The assertions take for granted a few things about the inputs:
- Every strobe is one cycle wide.
- `ext_bclk` is already synchronous to `clk`.
- `src_sel` and `bclk_int_sel` change only while the block is stopped.

The divider values, however, may change at any cycle, and the checks on the held active value are written for exactly that case. The stimulus obeys the same limits. It stops the block before it touches either select bit, and it changes divider values both in the middle of a half period and while the block is stopped. It raises start and stop in the same cycle to exercise the priority rule.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
package audclk_pkg;

  typedef enum logic {
    SRC_PERIPH = 1'b0,
    SRC_GEN    = 1'b1
  } src_sel_e;

  typedef enum logic {
    BCLK_EXTERNAL = 1'b0,
    BCLK_INTERNAL = 1'b1
  } bclk_src_e;

  // Source edges in one output half period: 2*div, or 1 in bypass.
  function automatic int unsigned half_period_edges(int unsigned div);
    return (div == 0) ? 1 : 2 * div;
  endfunction

  // Counter value at which the half period wraps.
  function automatic int unsigned wrap_count(int unsigned div);
    return half_period_edges(div) - 1;
  endfunction

endpackage

// File: rtl/audclk_run_ctrl.sv
`timescale 1ns/1ps
module audclk_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o
);

  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
    end
  end

  assign run_o = run_q;

  // Stop wins over a simultaneous start (R8)
  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run_o);

  assert_start_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> run_o);

endmodule

// File: rtl/audclk_edge_div.sv
`timescale 1ns/1ps
module audclk_edge_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             edge_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lvl_o,
  output logic             rise_o
);
  import audclk_pkg::*;

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;
  logic             lvl_q;
  logic             rise_q;
  logic [CNT_W-1:0] cnt_last;
  logic             wrap_evt;

  always_comb begin
    cnt_last = CNT_W'(wrap_count(32'(act_q)));
    wrap_evt = run_i && edge_i && (cnt_q == cnt_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      act_q  <= div_i;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= wrap_evt && !lvl_q;
      if (wrap_evt) begin
        cnt_q <= '0;
        lvl_q <= !lvl_q;
        act_q <= div_i;
      end else if (edge_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;

  // Output moves only on a counted source edge or on a stop (R3)
  assert_toggle_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(edge_i) || !$past(run_i)));

  // Stopped divider is cleared on the next cycle (R8)
  assert_stopped_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0 && !lvl_q && !rise_q));

  // Active divisor changes only at a wrap or while stopped (R9)
  assert_div_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wrap_evt) |=> $stable(act_q));

  // Rise pulse marks a 0-to-1 transition of the level (R7)
  assert_rise_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (lvl_q && !$past(lvl_q)));

endmodule

// File: rtl/audclk_ext_follow.sv
`timescale 1ns/1ps
module audclk_ext_follow (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ext_i,
  output logic lvl_o,
  output logic rise_o
);

  logic ext_q;
  logic ext_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q      <= 1'b0;
      ext_prev_q <= 1'b0;
    end else begin
      ext_q      <= ext_i;
      ext_prev_q <= ext_q;
    end
  end

  assign lvl_o  = run_i && ext_q;
  assign rise_o = run_i && ext_q && !ext_prev_q;

  // External tick is single-cycle and lands on a high level (R10)
  assert_ext_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  assert_ext_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> lvl_o);

endmodule

// File: rtl/audclk_gen.sv
`timescale 1ns/1ps
module audclk_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_periph,
  input  logic             edge_gen,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] mclk_div,
  input  logic [DIV_W-1:0] bclk_div,
  input  logic             mclk_gen_en,
  input  logic             bclk_int_sel,
  input  logic             ext_bclk,
  input  logic             clk_on,
  input  logic             clk_off,
  output logic             mclk,
  output logic             bclk,
  output logic             bclk_tick
);
  import audclk_pkg::*;

  logic run;
  logic src_edge;
  logic mdiv_run;
  logic bdiv_run;
  logic ext_run;
  logic m_lvl;
  logic m_rise;
  logic bi_lvl;
  logic bi_rise;
  logic be_lvl;
  logic be_rise;

  always_comb begin
    src_edge = (src_sel == SRC_GEN) ? edge_gen : edge_periph;
    mdiv_run = run && mclk_gen_en;
    bdiv_run = run && (bclk_int_sel == BCLK_INTERNAL);
    ext_run  = run && (bclk_int_sel == BCLK_EXTERNAL);
  end

  audclk_run_ctrl u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (clk_on),
    .stop_i  (clk_off),
    .run_o   (run)
  );

  audclk_edge_div #(.DIV_W(DIV_W)) u_mdiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (mdiv_run),
    .edge_i (src_edge),
    .div_i  (mclk_div),
    .lvl_o  (m_lvl),
    .rise_o (m_rise)
  );

  audclk_edge_div #(.DIV_W(DIV_W)) u_bdiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (bdiv_run),
    .edge_i (src_edge),
    .div_i  (bclk_div),
    .lvl_o  (bi_lvl),
    .rise_o (bi_rise)
  );

  audclk_ext_follow u_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (ext_run),
    .ext_i  (ext_bclk),
    .lvl_o  (be_lvl),
    .rise_o (be_rise)
  );

  assign mclk      = m_lvl;
  assign bclk      = (bclk_int_sel == BCLK_INTERNAL) ? bi_lvl  : be_lvl;
  assign bclk_tick = (bclk_int_sel == BCLK_INTERNAL) ? bi_rise : be_rise;

  // Master clock silenced when its mode bit is off (R6)
  assert_mclk_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_gen_en |=> !mclk);

  // Tick only while the bit clock is high (R7)
  assert_tick_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |-> bclk);

  // A stopped block drives no clocks (R8)
  assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> (!mclk && !bclk && !bclk_tick));

endmodule

// File: tb/audclk_gen_bench.sv
`timescale 1ns/1ps
module audclk_gen_bench;

  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          edge_periph = 1'b0;
  logic          edge_gen = 1'b0;
  logic          src_sel = 1'b0;
  logic [DW-1:0] mclk_div = '0;
  logic [DW-1:0] bclk_div = '0;
  logic          mclk_gen_en = 1'b0;
  logic          bclk_int_sel = 1'b1;
  logic          ext_bclk = 1'b0;
  logic          clk_on = 1'b0;
  logic          clk_off = 1'b0;
  logic          mclk;
  logic          bclk;
  logic          bclk_tick;

  always #10 clk = ~clk;

  audclk_gen #(.DIV_W(DW)) u_audclk_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .edge_periph  (edge_periph),
    .edge_gen     (edge_gen),
    .src_sel      (src_sel),
    .mclk_div     (mclk_div),
    .bclk_div     (bclk_div),
    .mclk_gen_en  (mclk_gen_en),
    .bclk_int_sel (bclk_int_sel),
    .ext_bclk     (ext_bclk),
    .clk_on       (clk_on),
    .clk_off      (clk_off),
    .mclk         (mclk),
    .bclk         (bclk),
    .bclk_tick    (bclk_tick)
  );

  typedef struct {
    bit    b;
    bit    m;
    bit    t;
    string tag;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Reference state: edges remaining in the current half period
  int b_rem = 1, m_rem = 1;
  bit b_lvl = 0, m_lvl = 0, b_tk = 0, m_tk = 0;
  bit ref_run = 0, eq = 0, eq_old = 0;

  function automatic int edges_per_half(int d);
    if (d == 0) return 1;
    return d + d;
  endfunction

  task automatic ref_div(input bit go, input bit e, input int dv,
                         inout int rem, inout bit lvl, output bit tk);
    tk = 0;
    if (!go) begin
      rem = edges_per_half(dv);
      lvl = 0;
    end else if (e) begin
      if (rem == 1) begin
        tk  = !lvl;
        lvl = !lvl;
        rem = edges_per_half(dv);
      end else begin
        rem = rem - 1;
      end
    end
  endtask

  // Driver: apply one cycle of inputs, predict, push expectation
  task automatic cyc(input bit ep, input bit eg, input bit on, input bit off,
                     input bit ext, input string tag);
    item_t it;
    bit    e;
    edge_periph = ep;
    edge_gen    = eg;
    clk_on      = on;
    clk_off     = off;
    ext_bclk    = ext;
    e = src_sel ? eg : ep;
    ref_div(ref_run && bclk_int_sel, e, int'(bclk_div), b_rem, b_lvl, b_tk);
    ref_div(ref_run && mclk_gen_en,  e, int'(mclk_div), m_rem, m_lvl, m_tk);
    if (off)     ref_run = 0;
    else if (on) ref_run = 1;
    eq_old = eq;
    eq     = ext;
    it.b   = bclk_int_sel ? b_lvl : (ref_run && eq);
    it.t   = bclk_int_sel ? b_tk  : (ref_run && eq && !eq_old);
    it.m   = m_lvl;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare a quarter period after each active edge
  always begin
    item_t it;
    @(posedge clk);
    #5;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      checks++;
      if (bclk !== it.b || mclk !== it.m || bclk_tick !== it.t) begin
        errors++;
        $display("FAIL %s at %0t: actual bclk=%b mclk=%b tick=%b expected bclk=%b mclk=%b tick=%b",
                 it.tag, $time, bclk, mclk, bclk_tick, it.b, it.m, it.t);
      end
    end
  end

  task automatic direct_check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual bclk=%b mclk=%b tick=%b expected 0 0 0",
               tag, what, bclk, mclk, bclk_tick);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet during and after reset
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #5;
      direct_check(!bclk && !mclk && !bclk_tick, "R1", "reset state");
    end
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, "R1");
    cyc(1, 1, 0, 0, 0, "R1");

    // R3 R5 R7: divide by 4 and by 2 on the peripheral source; R2 noise on the other stream
    bclk_div = 6'd2; mclk_div = 6'd1; mclk_gen_en = 1; bclk_int_sel = 1; src_sel = 0;
    cyc(1, 0, 1, 0, 0, "R8");
    for (int i = 0; i < 48; i++) cyc(i % 2 == 0, 1, 0, 0, 0, "R2/R3/R5/R7");

    // R2: switch to the generated source while stopped
    cyc(0, 0, 0, 1, 0, "R8");
    src_sel = 1;
    cyc(0, 0, 1, 0, 0, "R8");
    for (int i = 0; i < 36; i++) cyc(1, i % 3 == 0, 0, 0, 0, "R2/R3/R5");

    // R4 R9: bypass requested mid half period
    bclk_div = 6'd0; mclk_div = 6'd0;
    for (int i = 0; i < 24; i++) cyc(0, 1, 0, 0, 0, "R4/R9");

    // R9: larger divisors applied at the next wrap
    bclk_div = 6'd3; mclk_div = 6'd5;
    for (int i = 0; i < 30; i++) cyc(0, i % 2 == 1, 0, 0, 0, "R9/R3/R5");
    bclk_div = 6'd1;
    for (int i = 0; i < 30; i++) cyc(0, i % 2 == 1, 0, 0, 0, "R9/R7");

    // R6: master clock off, then back on
    mclk_gen_en = 0;
    for (int i = 0; i < 16; i++) cyc(0, 1, 0, 0, 0, "R6");
    mclk_gen_en = 1;
    for (int i = 0; i < 16; i++) cyc(0, 1, 0, 0, 0, "R6/R5");

    // R8: stop mid-run, start+stop together, strobe during start, restart
    cyc(0, 1, 0, 1, 0, "R8");
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 0, "R8");
    cyc(0, 1, 1, 1, 0, "R8");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0, "R8");
    bclk_div = 6'd2;
    cyc(0, 1, 1, 0, 0, "R8");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, 0, "R8/R3");

    // R10: external bit clock
    cyc(0, 0, 0, 1, 0, "R8");
    bclk_int_sel = 0;
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, i % 2 == 0, "R10");
    cyc(0, 1, 1, 0, 0, "R10");
    for (int i = 0; i < 30; i++) cyc(0, 1, 0, 0, (i / 3) % 2 == 1, "R10");
    cyc(0, 0, 0, 1, 1, "R10");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, i % 2 == 1, "R10");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule